// File: doc/BRIEF.md
# Register Scoreboard With Flag Register

This block holds the architectural register state of a pipelined core: sixteen general registers and one status-flag register. Every entry carries a data value and a ready bit. The decode stage uses two read ports to fetch source operands together with their ready bits. It also gets a single combinational signal that says whether every operand it asked for, including the flag register, is ready. When an instruction is allowed to issue, decode marks its destination register as pending. If the instruction produces flags, decode marks the flag register as pending as well.

The writeback stage later stores the result, marks the destination ready again and, for a flag-producing instruction, records whether the result was zero and marks the flag register ready. If an issue and a writeback hit the same entry in the same cycle, the issue's pending mark wins, because it belongs to the younger instruction. The writeback's value is still stored. Reads are combinational from the stored state. A writeback in progress is visible to the read ports only from the next cycle on.

Top module: `regfile_scoreboard`

## Requirements
- R1: During and after a synchronous active-high reset, every general register reads value 0 with ready bit 1, the flag register reads zero-flag 0 with ready bit 1, and sources_ready is 1.
- R2: Each read port returns, in the same cycle and combinationally, the stored value and ready bit of the general register selected by its 4-bit index (index n selects register n).
- R3: A cycle with issue_en=1 and issue_dst_en=1 clears the ready bit of register issue_dst_idx from the next cycle on and leaves its value unchanged.
- R4: A cycle with issue_en=1 and issue_flags=1 clears the flag register's ready bit from the next cycle on and leaves the zero flag unchanged.
- R5: A cycle with wb_en=1 stores wb_data in register wb_idx and sets its ready bit from the next cycle on.
- R6: A cycle with wb_flags=1 sets the flag register's ready bit and makes flag_zero 1 exactly when wb_data is all zeros, from the next cycle on.
- R7: When an issue clear and a writeback hit the same register, or both hit the flag register, in one cycle, the ready bit ends up 0, while the written value (or zero flag) still takes the writeback's data.
- R8: sources_ready is 1 exactly when every source whose enable (src_a_en, src_b_en, src_flag_en) is 1 has its ready bit set; it is 1 when no source is enabled.
- R9: A writeback changes only the register at wb_idx; a writeback with wb_flags=0 leaves the flag register unchanged.
- R10: With issue_en=0, the issue_dst_en, issue_dst_idx and issue_flags inputs have no effect on any ready bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_a_en | input | 1 | Source A is needed by the decoding instruction |
| src_a_idx | input | 4 | Source A register index |
| src_a_data | output | 32 | Source A value |
| src_a_valid | output | 1 | Source A ready bit |
| src_b_en | input | 1 | Source B is needed |
| src_b_idx | input | 4 | Source B register index |
| src_b_data | output | 32 | Source B value |
| src_b_valid | output | 1 | Source B ready bit |
| src_flag_en | input | 1 | Instruction reads the flag register |
| sources_ready | output | 1 | All enabled sources are ready |
| flag_zero | output | 1 | Stored zero flag |
| flag_valid | output | 1 | Flag register ready bit |
| issue_en | input | 1 | Decode issues an instruction this cycle |
| issue_dst_en | input | 1 | Issued instruction writes a general register |
| issue_dst_idx | input | 4 | Destination index of the issued instruction |
| issue_flags | input | 1 | Issued instruction produces flags |
| wb_en | input | 1 | Writeback stores a general register |
| wb_idx | input | 4 | Writeback destination index |
| wb_data | input | 32 | Writeback result |
| wb_flags | input | 1 | Writeback updates the flag register |

## Verification
A wrong ready bit or value shows up at a read port one cycle after the issue or writeback that caused it, as soon as that index is selected. It also shows up at once on sources_ready when that register is an enabled source. A wrong zero flag or flag ready bit is visible directly on flag_zero and flag_valid one cycle after the writeback or issue. Writing to one register corrupting a neighbour is only visible when the neighbour is read. For that reason the bench sweeps all sixteen indices after targeted updates.

// File: rtl/regsb_pkg.sv
package regsb_pkg;
    parameter int NUM_GPR = 16;
    parameter int DATA_W  = 32;
    parameter int IDX_W   = $clog2(NUM_GPR);

    // request to mark an entry pending (from issue)
    typedef struct packed {
        logic             en;
        logic [IDX_W-1:0] idx;
    } pend_req_t;

    // result returning from writeback
    typedef struct packed {
        logic              en;
        logic              flags;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] data;
    } wb_req_t;

    function automatic logic is_zero(input logic [DATA_W-1:0] v);
        return (v == '0);
    endfunction
endpackage

// File: rtl/gpr_bank.sv
module gpr_bank
    import regsb_pkg::*;
#(
    parameter int NREG = NUM_GPR,
    parameter int DW   = DATA_W,
    parameter int AW   = IDX_W
) (
    input  logic          clk,
    input  logic          rst,
    input  pend_req_t     pend,
    input  wb_req_t       wb,
    input  logic [AW-1:0] rd_a_idx,
    output logic [DW-1:0] rd_a_data,
    output logic          rd_a_vld,
    input  logic [AW-1:0] rd_b_idx,
    output logic [DW-1:0] rd_b_data,
    output logic          rd_b_vld
);
    logic [DW-1:0]   val_q [NREG];
    logic [NREG-1:0] vld_q;

    for (genvar g = 0; g < NREG; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                val_q[g] <= '0;
                vld_q[g] <= 1'b1;
            end else begin
                if (wb.en && (wb.idx == AW'(g))) begin
                    val_q[g] <= wb.data;
                    vld_q[g] <= 1'b1;
                end
                // younger instruction's pending mark wins
                if (pend.en && (pend.idx == AW'(g)))
                    vld_q[g] <= 1'b0;
            end
        end
    end

    assign rd_a_data = val_q[rd_a_idx];
    assign rd_a_vld  = vld_q[rd_a_idx];
    assign rd_b_data = val_q[rd_b_idx];
    assign rd_b_vld  = vld_q[rd_b_idx];

    assert_reset_ready_R1: assert property (@(posedge clk)
        rst |=> (vld_q == '1) && (val_q[0] == '0));

    assert_pend_clears_R3: assert property (@(posedge clk) disable iff (rst)
        pend.en |=> !vld_q[$past(pend.idx)]);

    assert_wb_writes_R5: assert property (@(posedge clk) disable iff (rst)
        (wb.en && !(pend.en && pend.idx == wb.idx))
        |=> vld_q[$past(wb.idx)] && (val_q[$past(wb.idx)] == $past(wb.data)));

    assert_collision_R7: assert property (@(posedge clk) disable iff (rst)
        (wb.en && pend.en && pend.idx == wb.idx)
        |=> !vld_q[$past(wb.idx)] && (val_q[$past(wb.idx)] == $past(wb.data)));
endmodule

// File: rtl/flag_reg.sv
module flag_reg
    import regsb_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    pend_flags,
    input  wb_req_t wb,
    output logic    zero,
    output logic    vld
);
    logic zero_q, vld_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            zero_q <= 1'b0;
            vld_q  <= 1'b1;
        end else begin
            if (wb.flags) begin
                zero_q <= is_zero(wb.data);
                vld_q  <= 1'b1;
            end
            if (pend_flags)
                vld_q <= 1'b0;
        end
    end

    assign zero = zero_q;
    assign vld  = vld_q;

    assert_flag_reset_R1: assert property (@(posedge clk)
        rst |=> vld_q && !zero_q);

    assert_flag_pend_R4: assert property (@(posedge clk) disable iff (rst)
        (pend_flags && !wb.flags) |=> !vld_q && $stable(zero_q));

    assert_flag_zero_R6: assert property (@(posedge clk) disable iff (rst)
        (wb.flags && !pend_flags) |=> vld_q && (zero_q == ($past(wb.data) == '0)));

    assert_flag_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (!wb.flags && !pend_flags) |=> $stable(zero_q) && $stable(vld_q));
endmodule

// File: rtl/ready_check.sv
module ready_check (
    input  logic a_en,
    input  logic a_vld,
    input  logic b_en,
    input  logic b_vld,
    input  logic f_en,
    input  logic f_vld,
    output logic ready
);
    always_comb begin
        ready = (!a_en || a_vld) && (!b_en || b_vld) && (!f_en || f_vld);
        if (!a_en && !b_en && !f_en)
            assert_none_needed_R8: assert (ready);
    end
endmodule

// File: rtl/regfile_scoreboard.sv
module regfile_scoreboard
    import regsb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              src_a_en,
    input  logic [IDX_W-1:0]  src_a_idx,
    output logic [DATA_W-1:0] src_a_data,
    output logic              src_a_valid,
    input  logic              src_b_en,
    input  logic [IDX_W-1:0]  src_b_idx,
    output logic [DATA_W-1:0] src_b_data,
    output logic              src_b_valid,
    input  logic              src_flag_en,
    output logic              sources_ready,
    output logic              flag_zero,
    output logic              flag_valid,
    input  logic              issue_en,
    input  logic              issue_dst_en,
    input  logic [IDX_W-1:0]  issue_dst_idx,
    input  logic              issue_flags,
    input  logic              wb_en,
    input  logic [IDX_W-1:0]  wb_idx,
    input  logic [DATA_W-1:0] wb_data,
    input  logic              wb_flags
);
    pend_req_t pend;
    wb_req_t   wb;
    logic      pend_flags;

    // issue fields only count when an instruction actually issues
    always_comb begin
        pend.en    = issue_en && issue_dst_en;
        pend.idx   = issue_dst_idx;
        pend_flags = issue_en && issue_flags;
        wb.en      = wb_en;
        wb.flags   = wb_flags;
        wb.idx     = wb_idx;
        wb.data    = wb_data;
    end

    gpr_bank u_bank (
        .clk       (clk),
        .rst       (rst),
        .pend      (pend),
        .wb        (wb),
        .rd_a_idx  (src_a_idx),
        .rd_a_data (src_a_data),
        .rd_a_vld  (src_a_valid),
        .rd_b_idx  (src_b_idx),
        .rd_b_data (src_b_data),
        .rd_b_vld  (src_b_valid)
    );

    flag_reg u_flag (
        .clk        (clk),
        .rst        (rst),
        .pend_flags (pend_flags),
        .wb         (wb),
        .zero       (flag_zero),
        .vld        (flag_valid)
    );

    ready_check u_ready (
        .a_en  (src_a_en),
        .a_vld (src_a_valid),
        .b_en  (src_b_en),
        .b_vld (src_b_valid),
        .f_en  (src_flag_en),
        .f_vld (flag_valid),
        .ready (sources_ready)
    );

    assert_no_issue_effect_R10: assert property (@(posedge clk) disable iff (rst)
        (!issue_en && !wb_en && !wb_flags) |=> $stable(src_a_valid) || $changed(src_a_idx));
endmodule

// File: tb/sim_regfile_scoreboard.sv
module sim_regfile_scoreboard;
    import regsb_pkg::*;

    logic clk = 1'b0;
    logic rst;
    logic src_a_en, src_b_en, src_flag_en;
    logic [IDX_W-1:0] src_a_idx, src_b_idx, issue_dst_idx, wb_idx;
    logic [DATA_W-1:0] src_a_data, src_b_data, wb_data;
    logic src_a_valid, src_b_valid, sources_ready, flag_zero, flag_valid;
    logic issue_en, issue_dst_en, issue_flags, wb_en, wb_flags;

    int n_chk = 0;
    int n_bad = 0;
    logic [DATA_W-1:0] m_val [NUM_GPR];
    logic m_vld [NUM_GPR];
    logic m_fz, m_fv;

    always #5 clk = ~clk;

    regfile_scoreboard u0 (.*);

    task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle();
        issue_en = 0; issue_dst_en = 0; issue_dst_idx = 0; issue_flags = 0;
        wb_en = 0; wb_idx = 0; wb_data = 0; wb_flags = 0;
        src_a_en = 0; src_b_en = 0; src_flag_en = 0;
    endtask

    // one clock edge; inputs return to idle afterwards
    task automatic tick();
        @(posedge clk); #2;
        idle();
        #1;
    endtask

    task automatic sweep(input string tag);
        for (int i = 0; i < NUM_GPR; i++) begin
            src_a_idx = IDX_W'(i); src_b_idx = IDX_W'(NUM_GPR - 1 - i); #1;
            chk(src_a_data === m_val[i] && src_a_valid === m_vld[i], tag,
                {src_a_valid, src_a_data}, {m_vld[i], m_val[i]});
            chk(src_b_data === m_val[NUM_GPR-1-i] && src_b_valid === m_vld[NUM_GPR-1-i], tag,
                {src_b_valid, src_b_data}, {m_vld[NUM_GPR-1-i], m_val[NUM_GPR-1-i]});
        end
        chk(flag_zero === m_fz && flag_valid === m_fv, {tag, " flag"},
            {flag_valid, flag_zero}, {m_fv, m_fz});
    endtask

    task automatic t_reset();
        rst = 1; idle(); src_a_idx = 0; src_b_idx = 0;
        @(posedge clk); @(posedge clk); #2;
        for (int i = 0; i < NUM_GPR; i++) begin m_val[i] = '0; m_vld[i] = 1; end
        m_fz = 0; m_fv = 1;
        sweep("R1 reset");
        src_a_en = 1; src_b_en = 1; src_flag_en = 1; #1;
        chk(sources_ready === 1'b1, "R1 ready after reset", sources_ready, 1);
        rst = 0; idle(); tick();
    endtask

    task automatic t_write_read();
        for (int i = 0; i < NUM_GPR; i++) begin
            wb_en = 1; wb_idx = IDX_W'(i); wb_data = 32'hA5000000 + DATA_W'(i * 17);
            m_val[i] = wb_data; m_vld[i] = 1;
            tick();
        end
        sweep("R5/R2 write-read");
    endtask

    task automatic t_issue_clear();
        issue_en = 1; issue_dst_en = 1; issue_dst_idx = 4'd7;
        m_vld[7] = 0;
        tick();
        sweep("R3 issue clear");
        src_a_en = 1; src_a_idx = 4'd7; src_b_en = 1; src_b_idx = 4'd2; #1;
        chk(sources_ready === 1'b0, "R8 pending source blocks", sources_ready, 0);
        src_a_en = 0; #1;
        chk(sources_ready === 1'b1, "R8 disabled source ignored", sources_ready, 1);
        idle();
        wb_en = 1; wb_idx = 4'd7; wb_data = 32'h12345678;
        m_val[7] = wb_data; m_vld[7] = 1;
        tick();
        sweep("R5 wb restores ready");
    endtask

    task automatic t_flags();
        issue_en = 1; issue_flags = 1; m_fv = 0;
        tick();
        chk(flag_valid === 0 && flag_zero === m_fz, "R4 flag pending", {flag_valid, flag_zero}, {1'b0, m_fz});
        src_flag_en = 1; #1;
        chk(sources_ready === 0, "R8 flag source pending", sources_ready, 0);
        idle();
        wb_flags = 1; wb_data = '0; m_fz = 1; m_fv = 1;
        tick();
        chk(flag_zero === 1 && flag_valid === 1, "R6 zero result", {flag_valid, flag_zero}, 2'b11);
        wb_flags = 1; wb_data = 32'h80000000; m_fz = 0;
        tick();
        chk(flag_zero === 0 && flag_valid === 1, "R6 nonzero result", {flag_valid, flag_zero}, 2'b10);
        wb_en = 1; wb_idx = 4'd3; wb_data = '0; m_val[3] = '0; m_vld[3] = 1;
        tick();
        chk(flag_zero === 0 && flag_valid === 1, "R9 wb without flags keeps flag", {flag_valid, flag_zero}, 2'b10);
        sweep("R9 isolation");
    endtask

    task automatic t_collision();
        issue_en = 1; issue_dst_en = 1; issue_dst_idx = 4'd9;
        wb_en = 1; wb_idx = 4'd9; wb_data = 32'hDEADBEEF;
        issue_flags = 1; wb_flags = 1;
        m_val[9] = 32'hDEADBEEF; m_vld[9] = 0; m_fv = 0; m_fz = 0;
        tick();
        sweep("R7 collision");
        issue_en = 1; issue_flags = 1; wb_flags = 1; wb_data = '0; m_fz = 1; m_fv = 0;
        tick();
        chk(flag_zero === 1 && flag_valid === 0, "R7 flag collision", {flag_valid, flag_zero}, 2'b01);
        wb_en = 1; wb_idx = 4'd9; wb_data = 32'h1; wb_flags = 1; m_val[9] = 1; m_vld[9] = 1;
        m_fz = 0; m_fv = 1;
        tick();
        sweep("R5 recover after collision");
    endtask

    task automatic t_issue_gate();
        issue_en = 0; issue_dst_en = 1; issue_dst_idx = 4'd4; issue_flags = 1;
        tick();
        sweep("R10 issue_en low ignored");
        issue_en = 1; issue_dst_en = 0; issue_dst_idx = 4'd5;
        tick();
        sweep("R10 dst_en low ignored");
    endtask

    task automatic t_ready();
        issue_en = 1; issue_dst_en = 1; issue_dst_idx = 4'd1; m_vld[1] = 0;
        tick();
        src_a_idx = 4'd1; src_b_idx = 4'd1;
        for (int m = 0; m < 8; m++) begin
            src_a_en = m[0]; src_b_en = m[1]; src_flag_en = m[2]; #1;
            chk(sources_ready === !(m[0] || m[1]), "R8 ready combos", sources_ready, !(m[0] || m[1]));
        end
        idle();
        src_a_idx = 4'd0; src_b_idx = 4'd2; src_a_en = 1; src_b_en = 1; src_flag_en = 1; #1;
        chk(sources_ready === 1, "R8 all ready", sources_ready, 1);
        idle();
    endtask

    initial begin
        t_reset();
        t_write_read();
        t_issue_clear();
        t_flags();
        t_collision();
        t_issue_gate();
        t_ready();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule